// File: doc/BRIEF.md
# DSP Peripheral Control Register Block

This block decodes the peripheral register accesses of a 24-bit DSP core. It holds a small interrupt status register whose bits are cleared by writing ones, and a separately latched DMA end-of-list flag that appears in that register's read value. It also holds a sticky idle request driven from a control address, and an address window that forwards four DMA engine registers to an external engine port.

A retirement timer sits beside the window. Each retired instruction is counted while the engine reports its control running bit. When the count passes its limit, the block sends the engine a one-cycle stop request. The engine then clears running (control bit 0) and sets stopped (control bit 1). Read data is registered and stays unchanged until the next read. Writes take effect on the clock edge at which the strobe is sampled.

Top module: `dsp_periph_ctrl`

## Requirements
- R1: After reset, the idle output is 0, the stop request is 0, read data is 0, and the status register reads 0x000000. A reset applied mid-run clears all status bits, the end-of-list flag, the idle output and the retirement counter.
- R2: A read of any address outside the mapped set returns 0x0ABABA. A write to such an address changes no state.
- R3: A read of address 0xFFFFB3 returns 0x000000.
- R4: A read of status address 0xFFFFC5 returns bit 0 = abort-frame, bit 1 = start-frame, bit 7 = end-of-list flag, and zero in every other bit.
- R5: A `frame_start` pulse sets status bit 1. A `dma_eol` pulse sets the end-of-list flag.
- R6: A write to 0xFFFFC5 clears each status bit whose position is 1 in the written data and leaves the other bits unchanged. Written bit 7 clears the end-of-list flag.
- R7: When a set pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: A write to 0xFFFFC4 with data bit 0 = 1 raises `core_idle`, which then stays high until reset. A write there with bit 0 = 0 has no effect.
- R9: An access to 0xFFFFD4/D5/D6/D7 asserts `dma_sel` in the same cycle, with `dma_idx` = 0/1/2/3 (next-block, start-block, control, configuration). `dma_we` and `dma_wdata` follow the bus. A read returns `dma_rdata`.
- R10: The third `instr_retired` strobe seen while `dma_running` is high gives a one-cycle `dma_stop` pulse in the next cycle, and the count restarts from zero. Strobes seen while `dma_running` is low are not counted.
- R11: Read data appears on `bus_rdata` one clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe from the core |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Peripheral address |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Registered read data |
| frame_start | input | 1 | Start-of-frame event pulse |
| dma_eol | input | 1 | DMA end-of-list event pulse |
| instr_retired | input | 1 | One instruction retired this cycle |
| core_idle | output | 1 | Sticky idle request to the core |
| dma_sel | output | 1 | Access strobe to the DMA engine |
| dma_we | output | 1 | Write enable to the DMA engine |
| dma_idx | output | 2 | DMA register select |
| dma_wdata | output | 24 | Write data to the DMA engine |
| dma_rdata | input | 24 | Read data from the DMA engine |
| dma_running | input | 1 | Engine control running bit |
| dma_stop | output | 1 | Request to clear running and set stopped |

## Verification
The hardest state to reach is a set event and a clearing write landing on the same status bit in the same cycle. The bench drives `frame_start`, `dma_eol` and a status write with bits 1 and 7 set all at one falling edge, then reads the status back. The retirement timer depends on an engine that reacts to the stop request, so the bench models the engine's four registers. Because the model clears its own running bit, the bench can show that strobes seen while the engine is stopped do not count toward the next stop.

// File: rtl/dsp_periph_ctrl.sv
module dsp_periph_ctrl #(
  parameter int          AW         = 24,
  parameter int          DW         = 24,
  parameter int          STOP_AFTER = 3,
  parameter logic [23:0] A_ZERO     = 24'hFFFFB3,
  parameter logic [23:0] A_IDLE     = 24'hFFFFC4,
  parameter logic [23:0] A_STAT     = 24'hFFFFC5,
  parameter logic [23:0] A_DMA      = 24'hFFFFD4,
  parameter logic [23:0] FILL       = 24'h0ABABA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          frame_start,
  input  logic          dma_eol,
  input  logic          instr_retired,
  output logic          core_idle,
  output logic          dma_sel,
  output logic          dma_we,
  output logic [1:0]    dma_idx,
  output logic [DW-1:0] dma_wdata,
  input  logic [DW-1:0] dma_rdata,
  input  logic          dma_running,
  output logic          dma_stop
);
  localparam int CW = $clog2(STOP_AFTER + 1);

  logic [1:0]    stat_q;
  logic          eol_q;
  logic [CW-1:0] cnt_q;
  logic          rd, wr, hit_zero, hit_idle, hit_stat, hit_dma;
  logic [DW-1:0] stat_view, rmux;

  assign rd       = bus_sel && !bus_we;
  assign wr       = bus_sel && bus_we;
  assign hit_zero = bus_addr == AW'(A_ZERO);
  assign hit_idle = bus_addr == AW'(A_IDLE);
  assign hit_stat = bus_addr == AW'(A_STAT);
  assign hit_dma  = bus_addr[AW-1:2] == AW'(A_DMA) >> 2;

  assign dma_sel   = bus_sel && hit_dma;
  assign dma_we    = bus_we;
  assign dma_idx   = bus_addr[1:0];
  assign dma_wdata = bus_wdata;

  always_comb begin
    stat_view      = '0;
    stat_view[1:0] = stat_q;
    stat_view[7]   = eol_q;
  end

  always_comb begin
    if (hit_stat)      rmux = stat_view;
    else if (hit_dma)  rmux = dma_rdata;
    else if (hit_zero) rmux = '0;
    else               rmux = DW'(FILL);
  end

  logic [1:0] clr_bits;
  logic       clr_eol;
  assign clr_bits = (wr && hit_stat) ? bus_wdata[1:0] : 2'b00;
  assign clr_eol  = wr && hit_stat && bus_wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q    <= '0;
      eol_q     <= 1'b0;
      core_idle <= 1'b0;
      bus_rdata <= '0;
      cnt_q     <= '0;
      dma_stop  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | {frame_start, 1'b0};
      eol_q  <= (eol_q && !clr_eol) || dma_eol;
      if (wr && hit_idle && bus_wdata[0]) core_idle <= 1'b1;
      if (rd) bus_rdata <= rmux;
      dma_stop <= 1'b0;
      if (instr_retired && dma_running) begin
        if (cnt_q == CW'(STOP_AFTER - 1)) begin
          cnt_q    <= '0;
          dma_stop <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  a_r8_idle_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    core_idle |=> core_idle);
  a_r5_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> stat_q[1]);
  a_r7_eol_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dma_eol |=> eol_q);
  a_r10_stop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stop |-> $past(instr_retired && dma_running));
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stop |=> !dma_stop);
  a_r2_fill: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !hit_stat && !hit_dma && !hit_zero |=> bus_rdata == DW'(FILL));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_dsp_periph_ctrl.sv
module test_dsp_periph_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [23:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic        frame_start = 0, dma_eol = 0, instr_retired = 0;
  logic        core_idle, dma_sel, dma_we, dma_stop;
  logic [1:0]  dma_idx;
  logic [23:0] dma_wdata, dma_rdata;
  logic [23:0] eng [4];
  logic        dma_running;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  dsp_periph_ctrl i_dsp_periph_ctrl (
    .clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .frame_start, .dma_eol, .instr_retired, .core_idle, .dma_sel, .dma_we,
    .dma_idx, .dma_wdata, .dma_rdata, .dma_running, .dma_stop);

  assign dma_rdata   = eng[dma_idx];
  assign dma_running = eng[2][0];
  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 4; i++) eng[i] <= '0;
    else begin
      if (dma_sel && dma_we) eng[dma_idx] <= dma_wdata;
      if (dma_stop) eng[2][1:0] <= 2'b10;
    end
  end

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(logic we, logic [23:0] a, logic [23:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd_chk(string req, logic [23:0] a, logic [23:0] exp);
    acc(0, a, 0);
    chk(req, bus_rdata, exp);
  endtask

  task automatic retire(string req, logic exp_stop);
    @(negedge clk);
    instr_retired = 1;
    @(negedge clk);
    instr_retired = 0;
    chk(req, {23'd0, dma_stop}, {23'd0, exp_stop});
  endtask

  localparam int NV = 20;
  // op: 0 write, 1 read-check, 2 frame_start pulse, 3 eol pulse
  localparam logic [49:0] VEC [NV] = '{
    {2'd1, 24'hFFFFB3, 24'h000000},
    {2'd1, 24'h000100, 24'h0ABABA},
    {2'd1, 24'hFFFFC6, 24'h0ABABA},
    {2'd0, 24'hFFFFC3, 24'hFFFFFF},
    {2'd1, 24'hFFFFC5, 24'h000000},
    {2'd2, 24'h000000, 24'h000000},
    {2'd1, 24'hFFFFC5, 24'h000002},
    {2'd3, 24'h000000, 24'h000000},
    {2'd1, 24'hFFFFC5, 24'h000082},
    {2'd0, 24'hFFFFC5, 24'h000002},
    {2'd1, 24'hFFFFC5, 24'h000080},
    {2'd0, 24'hFFFFC5, 24'h000001},
    {2'd1, 24'hFFFFC5, 24'h000080},
    {2'd0, 24'hFFFFC5, 24'h000080},
    {2'd1, 24'hFFFFC5, 24'h000000},
    {2'd0, 24'hFFFFD4, 24'h111111},
    {2'd0, 24'hFFFFD7, 24'h777777},
    {2'd1, 24'hFFFFD4, 24'h111111},
    {2'd1, 24'hFFFFD7, 24'h777777},
    {2'd1, 24'hFFFFD5, 24'h000000}
  };

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 idle", {23'd0, core_idle}, 0);
    chk("R1 stop", {23'd0, dma_stop}, 0);
    rd_chk("R1 status", 24'hFFFFC5, 0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][49:48])
        2'd0: acc(1, VEC[i][47:24], VEC[i][23:0]);
        2'd1: rd_chk("R2 R3 R4 R5 R6 R9 R11 vector", VEC[i][47:24], VEC[i][23:0]);
        2'd2: begin @(negedge clk); frame_start = 1; @(negedge clk); frame_start = 0; end
        default: begin @(negedge clk); dma_eol = 1; @(negedge clk); dma_eol = 0; end
      endcase
    end

    // R9 same-cycle forwarding
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 24'hFFFFD5; bus_wdata = 24'h5A5A5A;
    #1;
    chk("R9 sel", {23'd0, dma_sel}, 1);
    chk("R9 idx", {22'd0, dma_idx}, 1);
    chk("R9 wdata", dma_wdata, 24'h5A5A5A);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    rd_chk("R9 readback", 24'hFFFFD5, 24'h5A5A5A);
    // R11 hold
    repeat (3) @(negedge clk);
    chk("R11 hold", bus_rdata, 24'h5A5A5A);

    // R7 set wins over clear
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 24'hFFFFC5; bus_wdata = 24'h000082;
    frame_start = 1; dma_eol = 1;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; frame_start = 0; dma_eol = 0;
    rd_chk("R7 set wins", 24'hFFFFC5, 24'h000082);

    // R8 idle
    acc(1, 24'hFFFFC4, 24'hFFFFFE);
    chk("R8 bit0 clear no effect", {23'd0, core_idle}, 0);
    acc(1, 24'hFFFFC4, 24'h000001);
    chk("R8 idle set", {23'd0, core_idle}, 1);
    acc(1, 24'hFFFFC4, 24'h000000);
    chk("R8 idle sticky", {23'd0, core_idle}, 1);

    // R10 timer
    acc(1, 24'hFFFFD6, 24'h000001);
    retire("R10 first", 0);
    retire("R10 second", 0);
    rd_chk("R10 still running", 24'hFFFFD6, 24'h000001);
    retire("R10 third", 1);
    @(negedge clk);
    chk("R10 pulse ends", {23'd0, dma_stop}, 0);
    rd_chk("R10 stopped", 24'hFFFFD6, 24'h000002);
    for (int k = 0; k < 5; k++) retire("R10 idle not counted", 0);
    acc(1, 24'hFFFFD6, 24'h000001);
    retire("R10 restart 1", 0);
    retire("R10 restart 2", 0);
    retire("R10 restart 3", 1);

    // R1 mid-run reset
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 idle after reset", {23'd0, core_idle}, 0);
    rd_chk("R1 status after reset", 24'hFFFFC5, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule